// File: doc/BRIEF.md
# Parallel Handshaked RAM Bootstrap Loader

This controller fills a region of on-chip RAM with bytes read from an external byte source over a parallel port. It then hands execution to the loaded code. At start-up it reads an active-low security input. If security is engaged, the block loads nothing and stays in a lockout state, where it blinks a status LED. Otherwise it puts a byte index on an address bus, so that a memory such as an EPROM can be read in sequence. It toggles a request strobe for every new byte and takes the 8-bit data bus once the acknowledge level equals the request level. Each captured byte is written to consecutive RAM locations, starting at the entry address 0x0050.

Before each new byte the block samples an active-low stop input. Loading ends when that input is low, or when the whole RAM region has been written. The block then raises a one-clock done pulse with the 16-bit entry address and stays idle until reset.

If acknowledge is tied straight to request, the handshake is always satisfied. Each byte is then paced only by the internal timers: a settle count from the address change to the data sample, and a total load-cycle length. Both timers are set in machine cycles of `MC_CLKS` clocks each.

Top module: `ram_boot_loader`

## Requirements
- R1: If secN is 0 at the first clock after reset, no RAM write, no done pulse and no reqOut edge ever occurs. ledOut toggles every FLASH_HALF_CLKS clocks.
- R2: Outside the lockout state, ledOut stays 0.
- R3: Byte k (counting from 0) is read with extAddr = k. It is written with ramAddr = ENTRY_ADDR + k (0x0050 + k), and ramWData equals the value present on dataIn for address k.
- R4: stopN is sampled before each new byte is fetched. If it is 0, no further byte is fetched and done follows. If stopN is 0 from the start, zero bytes are loaded.
- R5: After RAM_BYTES bytes have been written, loading stops and done follows, with no further write.
- R6: doneOut is high for exactly one clock per load. entryAddr equals 0x0050 during that clock and is 0 at all other times.
- R7: After done, no RAM write and no reqOut edge occur until reset.
- R8: reqOut changes level exactly once per fetched byte, and its first edge after reset is a rise.
- R9: A byte is captured only while ackIn equals reqOut. With a slow acknowledge, the write follows the acknowledge match by exactly one clock.
- R10: The data sample never occurs earlier than SETTLE_MC*MC_CLKS clocks after the address and request change. With acknowledge already matched, ramWe is seen exactly SETTLE_MC*MC_CLKS+1 clocks after the reqOut edge.
- R11: With ackIn tied to reqOut, successive RAM writes are exactly LOAD_MC*MC_CLKS clocks apart.
- R12: During reset, reqOut, ramWe, doneOut, ledOut, extAddr and entryAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secN | input | 1 | Security input, 0 = locked |
| stopN | input | 1 | Early-stop input, 0 = end loading |
| extAddr | output | EXT_AW | Byte index presented to the external source |
| dataIn | input | 8 | Byte from the external source |
| reqOut | output | 1 | Request strobe, toggles once per byte |
| ackIn | input | 1 | Acknowledge strobe |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 16 | RAM write address |
| ramWData | output | 8 | RAM write data |
| ledOut | output | 1 | Lockout indicator LED |
| doneOut | output | 1 | One-clock hand-off pulse |
| entryAddr | output | 16 | Entry address, valid with doneOut |

## Verification
The load is run to completion in three acknowledge patterns:
- **Looped:** acknowledge is tied to request. This isolates the settle and load-cycle timers.
- **Fast responder:** acknowledge arrives inside the settle window. This shows the settle count still rules.
- **Slow responder:** acknowledge arrives well after the settle window. This shows the capture waits for the acknowledge match and not for the timer.

A data pattern that differs per address catches any address or ordering slip in every written byte.

Stop is asserted from the start and again in the middle of a load. These runs tell the per-byte stop poll apart from the RAM-full ending.

A run with security low checks that the lockout blocks all traffic and that the LED blinks at its set half-period.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_CHECK, ST_POLL, ST_WAIT, ST_HOLD, ST_FINISH, ST_IDLE, ST_LOCK
  } bootState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic nextByte;
    logic capture;
    logic finish;
    logic lock;
  } ctlStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic full;
    logic settled;
    logic cycleDone;
  } dpStatus_t;
endpackage

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secN,
  input  logic       stopN,
  input  logic       ackIn,
  input  logic       reqLevel,
  input  dpStatus_t  stat,
  output ctlStrobe_t strobe
);
  bootState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CHECK;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_CHECK: stateNext = secN ? ST_POLL : ST_LOCK;
      ST_POLL: begin
        if (!stopN || stat.full) begin
          stateNext = ST_FINISH;
        end else begin
          strobe.nextByte = 1'b1;
          stateNext       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stat.settled && (ackIn == reqLevel)) begin
          strobe.capture = 1'b1;
          stateNext      = ST_HOLD;
        end
      end
      ST_HOLD:   if (stat.cycleDone) stateNext = ST_POLL;
      ST_FINISH: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_IDLE:   stateNext = ST_IDLE;
      ST_LOCK:   strobe.lock = 1'b1;
      default:   stateNext = ST_CHECK;
    endcase
  end
endmodule

// File: rtl/boot_dpath.sv
module boot_dpath
  import boot_pkg::*;
#(
  parameter int          RAM_BYTES  = 352,
  parameter int          EXT_AW     = 16,
  parameter logic [15:0] ENTRY_ADDR = 16'h0050,
  parameter int          SETTLE_CLK = 10,
  parameter int          CYCLE_CLK  = 60,
  parameter int          FLASH_HALF = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        dataIn,
  output dpStatus_t         stat,
  output logic [EXT_AW-1:0] extAddr,
  output logic              reqOut,
  output logic              ramWe,
  output logic [15:0]       ramAddr,
  output logic [7:0]        ramWData,
  output logic              ledOut,
  output logic              doneOut,
  output logic [15:0]       entryAddr
);
  localparam int CNT_W = $clog2(RAM_BYTES + 1);
  localparam int TMR_W = $clog2(CYCLE_CLK + 1);
  localparam int FL_W  = $clog2(FLASH_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(RAM_BYTES);
  localparam logic [TMR_W-1:0] TMR_MAX   = TMR_W'(CYCLE_CLK);
  localparam logic [TMR_W-1:0] TMR_SET   = TMR_W'(SETTLE_CLK);
  localparam logic [TMR_W-1:0] TMR_END   = TMR_W'(CYCLE_CLK - 2);
  localparam logic [FL_W-1:0]  FLASH_END = FL_W'(FLASH_HALF - 1);

  logic [CNT_W-1:0] byteCnt;
  logic [TMR_W-1:0] timer;
  logic [FL_W-1:0]  flashCnt;

  // byte counter, address and request strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      extAddr <= '0;
      reqOut  <= 1'b0;
    end else begin
      if (strobe.nextByte) begin
        extAddr <= EXT_AW'(byteCnt);
        reqOut  <= ~reqOut;
      end
      if (strobe.capture) byteCnt <= byteCnt + 1'b1;
    end
  end

  // per-byte timer, cleared on each new address, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  timer <= '0;
    else if (strobe.nextByte)   timer <= '0;
    else if (timer != TMR_MAX)  timer <= timer + 1'b1;
  end

  // RAM write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramWData <= '0;
    end else begin
      ramWe <= strobe.capture;
      if (strobe.capture) begin
        ramAddr  <= ENTRY_ADDR + 16'(byteCnt);
        ramWData <= dataIn;
      end
    end
  end

  // hand-off pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneOut   <= 1'b0;
      entryAddr <= '0;
    end else begin
      doneOut   <= strobe.finish;
      entryAddr <= strobe.finish ? ENTRY_ADDR : 16'h0000;
    end
  end

  // lockout blink
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCnt <= '0;
      ledOut   <= 1'b0;
    end else if (strobe.lock) begin
      if (flashCnt == FLASH_END) begin
        flashCnt <= '0;
        ledOut   <= ~ledOut;
      end else begin
        flashCnt <= flashCnt + 1'b1;
      end
    end
  end

  assign stat.full      = (byteCnt == CNT_FULL);
  assign stat.settled   = (timer >= TMR_SET);
  assign stat.cycleDone = (timer >= TMR_END);
endmodule

// File: rtl/ram_boot_loader.sv
module ram_boot_loader
  import boot_pkg::*;
#(
  parameter int          RAM_BYTES       = 352,
  parameter int          EXT_AW          = 16,
  parameter logic [15:0] ENTRY_ADDR      = 16'h0050,
  parameter int          MC_CLKS         = 2,
  parameter int          SETTLE_MC       = 5,
  parameter int          LOAD_MC         = 30,
  parameter int          FLASH_HALF_CLKS = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secN,
  input  logic              stopN,
  output logic [EXT_AW-1:0] extAddr,
  input  logic [7:0]        dataIn,
  output logic              reqOut,
  input  logic              ackIn,
  output logic              ramWe,
  output logic [15:0]       ramAddr,
  output logic [7:0]        ramWData,
  output logic              ledOut,
  output logic              doneOut,
  output logic [15:0]       entryAddr
);
  localparam int SETTLE_CLK = SETTLE_MC * MC_CLKS;
  localparam int CYCLE_CLK  = LOAD_MC * MC_CLKS;

  ctlStrobe_t strobe;
  dpStatus_t  stat;

  boot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .secN     (secN),
    .stopN    (stopN),
    .ackIn    (ackIn),
    .reqLevel (reqOut),
    .stat     (stat),
    .strobe   (strobe)
  );

  boot_dpath #(
    .RAM_BYTES  (RAM_BYTES),
    .EXT_AW     (EXT_AW),
    .ENTRY_ADDR (ENTRY_ADDR),
    .SETTLE_CLK (SETTLE_CLK),
    .CYCLE_CLK  (CYCLE_CLK),
    .FLASH_HALF (FLASH_HALF_CLKS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .stat      (stat),
    .extAddr   (extAddr),
    .reqOut    (reqOut),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .ramWData  (ramWData),
    .ledOut    (ledOut),
    .doneOut   (doneOut),
    .entryAddr (entryAddr)
  );
endmodule

// File: rtl/ram_boot_loader_chk.sv
module ram_boot_loader_chk #(
  parameter int          RAM_BYTES  = 352,
  parameter int          EXT_AW     = 16,
  parameter logic [15:0] ENTRY_ADDR = 16'h0050
) (
  input logic              clk,
  input logic              rstN,
  input logic              ackIn,
  input logic              reqOut,
  input logic [EXT_AW-1:0] extAddr,
  input logic              ramWe,
  input logic [15:0]       ramAddr,
  input logic              ledOut,
  input logic              doneOut,
  input logic [15:0]       entryAddr
);
  logic doneSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        doneSeen <= 1'b0;
    else if (doneOut) doneSeen <= 1'b1;
  end

  p_lock_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    ledOut |-> (!ramWe && !doneOut));

  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr >= ENTRY_ADDR && ramAddr < ENTRY_ADDR + 16'(RAM_BYTES)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_entry_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (entryAddr == ENTRY_ADDR));

  p_idle_after_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> (!ramWe && $stable(reqOut)));

  p_match_needed_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(ackIn == reqOut));

  p_addr_settled_r10: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ($stable(extAddr) && $stable(reqOut)));
endmodule

bind ram_boot_loader ram_boot_loader_chk #(
  .RAM_BYTES  (RAM_BYTES),
  .EXT_AW     (EXT_AW),
  .ENTRY_ADDR (ENTRY_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ackIn     (ackIn),
  .reqOut    (reqOut),
  .extAddr   (extAddr),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .ledOut    (ledOut),
  .doneOut   (doneOut),
  .entryAddr (entryAddr)
);

// File: tb/ram_boot_loader_bench.sv
module ram_boot_loader_bench;
  localparam int BYTES     = 12;
  localparam int AW        = 16;
  localparam int MCC       = 2;
  localparam int SET_MC    = 3;
  localparam int LOADMC    = 8;
  localparam int FLASH     = 5;
  localparam int SET_CLK   = SET_MC * MCC;
  localparam int CYC_CLK   = LOADMC * MCC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secN = 1'b1;
  logic stopN = 1'b1;
  logic loopMode = 1'b1;
  logic ackReg = 1'b0;
  int   ackDly = 1;
  logic [AW-1:0] extAddr;
  logic [7:0]  dataIn;
  logic        reqOut, ackIn, ramWe, ledOut, doneOut;
  logic [15:0] ramAddr, entryAddr;
  logic [7:0]  ramWData;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // monitor state
  int  wrCount, reqEdges, doneCount, ledEdges, postDone;
  int  lastWrCyc, lastReqCyc, lastLedCyc;
  logic prevReq, prevLed, prevDone, doneSeen, monOn;

  always #4 clk = ~clk;

  function automatic logic [7:0] srcByte(input logic [AW-1:0] a);
    return 8'(a * 37 + 5) ^ 8'h5A;
  endfunction

  assign dataIn = srcByte(extAddr);
  assign ackIn  = loopMode ? reqOut : ackReg;

  ram_boot_loader #(
    .RAM_BYTES (BYTES), .EXT_AW (AW), .ENTRY_ADDR (16'h0050),
    .MC_CLKS (MCC), .SETTLE_MC (SET_MC), .LOAD_MC (LOADMC),
    .FLASH_HALF_CLKS (FLASH)
  ) u_ram_boot_loader (
    .clk (clk), .rstN (rstN), .secN (secN), .stopN (stopN),
    .extAddr (extAddr), .dataIn (dataIn), .reqOut (reqOut), .ackIn (ackIn),
    .ramWe (ramWe), .ramAddr (ramAddr), .ramWData (ramWData),
    .ledOut (ledOut), .doneOut (doneOut), .entryAddr (entryAddr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // external byte source with a delayed acknowledge
  initial begin
    int dlyCnt = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        ackReg = 1'b0;
        dlyCnt = 0;
      end else if (reqOut != ackReg) begin
        dlyCnt++;
        if (dlyCnt >= ackDly) begin
          ackReg = reqOut;
          dlyCnt = 0;
        end
      end else begin
        dlyCnt = 0;
      end
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (monOn && rstN) begin
      if (reqOut != prevReq) begin
        if (reqEdges == 0) check(reqOut == 1'b1, "R8 first edge rises", reqOut, 1);
        reqEdges++;
        lastReqCyc = cyc;
        if (doneSeen) postDone++;
      end
      if (ramWe) begin
        check(int'(ramAddr) == 16'h0050 + wrCount, "R3 ram address", ramAddr, 16'h0050 + wrCount);
        check(int'(extAddr) == wrCount, "R3 ext address", extAddr, wrCount);
        check(ramWData == srcByte(AW'(wrCount)), "R3 data", ramWData, srcByte(AW'(wrCount)));
        check(cyc - lastReqCyc >= SET_CLK + 1, "R10 settle minimum", cyc - lastReqCyc, SET_CLK + 1);
        if (loopMode || ackDly <= SET_CLK + 1)
          check(cyc - lastReqCyc == SET_CLK + 1, "R10 settle exact", cyc - lastReqCyc, SET_CLK + 1);
        else
          check(cyc - lastReqCyc == ackDly, "R9 wait for ack match", cyc - lastReqCyc, ackDly);
        if (loopMode && wrCount > 0)
          check(cyc - lastWrCyc == CYC_CLK, "R11 load cycle", cyc - lastWrCyc, CYC_CLK);
        lastWrCyc = cyc;
        wrCount++;
        if (doneSeen) postDone++;
      end
      if (doneOut) begin
        check(entryAddr == 16'h0050, "R6 entry address", entryAddr, 16'h0050);
        check(!prevDone, "R6 single clock", prevDone, 0);
        if (!prevDone) doneCount++;
        doneSeen = 1'b1;
      end else begin
        if (entryAddr != 16'h0000) check(1'b0, "R6 entry idle", entryAddr, 0);
      end
      if (ledOut != prevLed) begin
        if (secN) check(1'b0, "R2 led off", ledOut, 0);
        if (ledEdges > 0)
          check(cyc - lastLedCyc == FLASH, "R1 blink period", cyc - lastLedCyc, FLASH);
        ledEdges++;
        lastLedCyc = cyc;
      end
      prevReq  = reqOut;
      prevLed  = ledOut;
      prevDone = doneOut;
    end
  end

  task automatic startRun(input logic sec, input logic loopV, input int dly, input logic stopV);
    @(negedge clk);
    monOn  = 1'b0;
    rstN   = 1'b0;
    secN   = sec;
    loopMode = loopV;
    ackDly = dly;
    stopN  = stopV;
    repeat (2) @(negedge clk);
    check(!reqOut && !ramWe && !doneOut && !ledOut, "R12 reset outputs",
          {reqOut, ramWe, doneOut, ledOut}, 0);
    check(extAddr == '0 && entryAddr == '0, "R12 reset address", extAddr, 0);
    wrCount = 0; reqEdges = 0; doneCount = 0; ledEdges = 0; postDone = 0;
    lastWrCyc = 0; lastReqCyc = cyc; lastLedCyc = 0;
    prevReq = 1'b0; prevLed = 1'b0; prevDone = 1'b0; doneSeen = 1'b0;
    monOn = 1'b1;
    rstN  = 1'b1;
  endtask

  task automatic awaitDone(input int stopAt);
    int n = 0;
    while (!doneSeen && n < 5000) begin
      @(negedge clk);
      n++;
      if (stopAt >= 0 && wrCount >= stopAt) stopN = 1'b0;
    end
    repeat (60) @(negedge clk);
  endtask

  task automatic fullRun(input logic loopV, input int dly, input string tag);
    startRun(1'b1, loopV, dly, 1'b1);
    awaitDone(-1);
    check(wrCount == BYTES, {"R5 byte count ", tag}, wrCount, BYTES);
    check(reqEdges == BYTES, {"R8 req edges ", tag}, reqEdges, BYTES);
    check(doneCount == 1, {"R6 done pulses ", tag}, doneCount, 1);
    check(postDone == 0, {"R7 idle after done ", tag}, postDone, 0);
    check(ledEdges == 0, {"R2 led quiet ", tag}, ledEdges, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    monOn = 1'b0;
    fullRun(1'b1, 1, "looped");
    fullRun(1'b0, 20, "slow ack");
    fullRun(1'b0, 2, "fast ack");

    // R4: stop part-way through
    startRun(1'b1, 1'b1, 1, 1'b1);
    awaitDone(5);
    check(wrCount == 5, "R4 stop mid load", wrCount, 5);
    check(reqEdges == 5, "R8 req edges on stop", reqEdges, 5);
    check(doneCount == 1, "R4 done after stop", doneCount, 1);
    check(postDone == 0, "R7 idle after stop", postDone, 0);

    // R4: stop from the start
    startRun(1'b1, 1'b1, 1, 1'b0);
    awaitDone(-1);
    check(wrCount == 0, "R4 stop at start", wrCount, 0);
    check(reqEdges == 0, "R4 no request", reqEdges, 0);
    check(doneCount == 1, "R4 done at start", doneCount, 1);

    // R1: security lockout
    startRun(1'b0, 1'b1, 1, 1'b1);
    repeat (200) @(negedge clk);
    check(wrCount == 0, "R1 no writes", wrCount, 0);
    check(doneCount == 0, "R1 no done", doneCount, 0);
    check(reqEdges == 0, "R1 no request", reqEdges, 0);
    check(ledEdges >= 30, "R1 led blinking", ledEdges, 30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule